// File: doc/BRIEF.md
# Manchester Line Receiver with Collision Detect

This block recovers serial data from a Manchester-coded line. A reloadable baud divider produces a sample enable at eight times the bit rate, and the line is synchronised, sampled on that enable and measured in sample counts between transitions. Each transition is classed as short, half-bit, full-bit or long. A decoder uses that class to lock onto the bit timing during an alternating one/zero preamble. It then waits for the begin-of-frame marker of two consecutive one bits and delivers the decoded payload one bit per bit time with a single-cycle valid strobe.

Pulses that are too short to be legal Manchester are treated as a collision on a shared line. They set a sticky flag that stays set until it is cleared, and they abort the frame in progress. A line that rests high for two bit times ends the frame, and an end-of-frame pulse is issued. Byte assembly, CRC checking, address matching and buffering are left to the logic downstream.

Top module: `mrx_top`

## Requirements
- R1: The sample enable fires once every BAUD+1 clocks, so one bit time lasts 8*(BAUD+1) clocks. A value written with `baud_wr` enters a reload register and reaches the divider the next time the divider counts down to 0. Consecutive decoded bits of a clean frame are therefore exactly 8*(BAUD+1) clocks apart.
- R2: Each bit is decoded from its mid-bit transition: low-to-high gives 1 and high-to-low gives 0. Every payload bit appears on `bit_o` with a one-cycle `bit_vld_o` pulse, first bit on the line first. At most one of `bit_vld_o`, `sof_o` and `eof_o` is high in any cycle.
- R3: Between transitions, a level held for 3 to 5 samples counts as a half bit and 6 to 10 samples counts as a full bit. A mid-bit edge moved by one sample therefore still decodes correctly and does not raise the collision flag.
- R4: A transition 1 or 2 samples after the previous one sets `coll_o` and abandons the frame. No further bits are delivered until a new preamble and begin marker are seen.
- R5: Collision detection works the same way whether `rx_en` is high or low.
- R6: `coll_o` stays set until `coll_clr` is pulsed. If a collision arrives in the same cycle as the clear, the flag stays set.
- R7: The receiver locks on a full-bit-spaced alternating preamble. It then pulses `sof_o` on the mid-bit edge of the second of two consecutive one bits, and delivers no bits before that pulse.
- R8: Two consecutive zero bits after the preamble do not count as a begin marker: no `sof_o` and no bits follow.
- R9: Inside a frame, a line held high for 16 samples (two bit times) pulses `eof_o` once and returns the receiver to hunting. A line held low for more than 10 samples abandons the frame without `eof_o`.
- R10: While `rx_en` is low the decoder is held in hunting and issues no `bit_vld_o`, `sof_o` or `eof_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_wr | input | 1 | Write strobe for the divider reload value |
| baud_val | input | 8 | Divider reload value (BAUD) |
| rx_en | input | 1 | Receive enable |
| coll_clr | input | 1 | Clears the collision flag |
| line_in | input | 1 | Manchester-coded line, idle high |
| bit_o | output | 1 | Decoded bit value |
| bit_vld_o | output | 1 | One-cycle strobe, `bit_o` valid |
| sof_o | output | 1 | One-cycle pulse when the begin marker is found |
| eof_o | output | 1 | One-cycle pulse on line idle inside a frame |
| coll_o | output | 1 | Sticky collision flag |

## Verification
The bench sweeps four divider settings with several payloads. It measures the spacing of decoded bits in clocks, so a divider off by one clock, or a reload applied at the wrong time, would show up as bits arriving at the wrong rate. Frames with mid-bit edges moved by one sample check the jitter window: a decoder with a half-bit window that is too narrow would drop those bits or raise a false collision. Other frames insert a two-sample glitch, end the preamble with two zeros, hold the line low mid-frame, or run with reception disabled. A decoder that kept going after a glitch, accepted the wrong begin marker, reported end-of-frame on a stuck-low line or ignored the enable would deliver extra bits or pulses that the bench counts.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    // class of the interval between two line transitions
    typedef enum logic [1:0] {
        W_SHORT = 2'd0,
        W_HALF  = 2'd1,
        W_FULL  = 2'd2,
        W_LONG  = 2'd3
    } wcls_e;

    // decoder states
    typedef enum logic [2:0] {
        ST_HUNT = 3'd0,  // waiting for a full-bit spaced edge
        ST_SYNC = 3'd1,  // locked on preamble mid-bit edges
        ST_BOF  = 3'd2,  // saw a boundary edge, expecting second one
        ST_MID  = 3'd3,  // in frame, last edge was mid-bit
        ST_BND  = 3'd4   // in frame, last edge was a bit boundary
    } dec_st_e;

endpackage

// File: rtl/mrx_baud.sv
module mrx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] rld;
    } baud_t;

    baud_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (div_wr) begin
            st_d.rld = div_val;
        end
        if (st_q.cnt == '0) begin
            st_d.cnt = st_q.rld;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    assign tick = (st_q.cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mrx_edge.sv
module mrx_edge
    import mrx_pkg::*;
#(
    parameter int RUN_W    = 5,
    parameter int HALF_MIN = 3,
    parameter int HALF_MAX = 5,
    parameter int FULL_MAX = 10,
    parameter int IDLE_RUN = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  line_in,
    output logic  ev_edge,
    output logic  ev_rise,
    output wcls_e ev_cls,
    output logic  ev_idle
);

    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
    localparam logic [RUN_W-1:0] H_MIN_V = RUN_W'(HALF_MIN);
    localparam logic [RUN_W-1:0] H_MAX_V = RUN_W'(HALF_MAX);
    localparam logic [RUN_W-1:0] F_MAX_V = RUN_W'(FULL_MAX);
    localparam logic [RUN_W-1:0] IDLE_V  = RUN_W'(IDLE_RUN);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             samp;
        logic [RUN_W-1:0] run;
        logic             edge_ev;
        logic             rise;
        wcls_e            cls;
        logic             idle;
    } edge_t;

    edge_t st_d, st_q;
    logic [RUN_W-1:0] run_inc;

    function automatic wcls_e classify(input logic [RUN_W-1:0] n);
        if (n < H_MIN_V)       return W_SHORT;
        else if (n <= H_MAX_V) return W_HALF;
        else if (n <= F_MAX_V) return W_FULL;
        else                   return W_LONG;
    endfunction

    assign run_inc = st_q.run + 1'b1;

    always_comb begin
        st_d         = st_q;
        st_d.sync1   = line_in;
        st_d.sync2   = st_q.sync1;
        st_d.edge_ev = 1'b0;
        st_d.idle    = 1'b0;
        if (tick) begin
            st_d.samp = st_q.sync2;
            if (st_q.sync2 != st_q.samp) begin
                st_d.edge_ev = 1'b1;
                st_d.rise    = st_q.sync2;
                st_d.cls     = classify(st_q.run);
                st_d.run     = RUN_W'(1);
            end else if (st_q.run != RUN_MAX) begin
                st_d.run  = run_inc;
                st_d.idle = st_q.samp && (run_inc == IDLE_V);
            end
        end
    end

    assign ev_edge = st_q.edge_ev;
    assign ev_rise = st_q.rise;
    assign ev_cls  = st_q.cls;
    assign ev_idle = st_q.idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync1   <= 1'b1;
            st_q.sync2   <= 1'b1;
            st_q.samp    <= 1'b1;
            st_q.run     <= RUN_MAX;
            st_q.edge_ev <= 1'b0;
            st_q.rise    <= 1'b0;
            st_q.cls     <= W_LONG;
            st_q.idle    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mrx_decode.sv
module mrx_decode
    import mrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_en,
    input  logic  coll_clr,
    input  logic  ev_edge,
    input  logic  ev_rise,
    input  wcls_e ev_cls,
    input  logic  ev_idle,
    output logic  bit_o,
    output logic  bit_vld_o,
    output logic  sof_o,
    output logic  eof_o,
    output logic  coll_o
);

    typedef struct packed {
        dec_st_e st;
        logic    bval;
        logic    vld;
        logic    sof;
        logic    eof;
        logic    coll;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.sof = 1'b0;
        st_d.eof = 1'b0;

        // collision flag runs regardless of rx_en; a set beats a clear
        if (coll_clr) st_d.coll = 1'b0;
        if (ev_edge && ev_cls == W_SHORT) st_d.coll = 1'b1;

        if (!rx_en) begin
            st_d.st = ST_HUNT;
        end else if (ev_edge) begin
            if (ev_cls == W_SHORT || ev_cls == W_LONG) begin
                st_d.st = ST_HUNT;
            end else begin
                unique case (st_q.st)
                    ST_HUNT: begin
                        if (ev_cls == W_FULL) st_d.st = ST_SYNC;
                    end
                    ST_SYNC: begin
                        if (ev_cls == W_HALF) st_d.st = ST_BOF;
                    end
                    ST_BOF: begin
                        if (ev_cls == W_HALF && ev_rise) begin
                            st_d.sof = 1'b1;
                            st_d.st  = ST_MID;
                        end else begin
                            st_d.st = ST_HUNT;
                        end
                    end
                    ST_MID: begin
                        if (ev_cls == W_FULL) begin
                            st_d.vld  = 1'b1;
                            st_d.bval = ev_rise;
                        end else begin
                            st_d.st = ST_BND;
                        end
                    end
                    ST_BND: begin
                        if (ev_cls == W_HALF) begin
                            st_d.vld  = 1'b1;
                            st_d.bval = ev_rise;
                            st_d.st   = ST_MID;
                        end else begin
                            st_d.st = ST_HUNT;
                        end
                    end
                    default: st_d.st = ST_HUNT;
                endcase
            end
        end else if (ev_idle) begin
            if (st_q.st == ST_MID || st_q.st == ST_BND) st_d.eof = 1'b1;
            st_d.st = ST_HUNT;
        end
    end

    assign bit_o     = st_q.bval;
    assign bit_vld_o = st_q.vld;
    assign sof_o     = st_q.sof;
    assign eof_o     = st_q.eof;
    assign coll_o    = st_q.coll;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st   <= ST_HUNT;
            st_q.bval <= 1'b0;
            st_q.vld  <= 1'b0;
            st_q.sof  <= 1'b0;
            st_q.eof  <= 1'b0;
            st_q.coll <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mrx_top.sv
module mrx_top
    import mrx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int RUN_W    = 5,
    parameter int HALF_MIN = 3,
    parameter int HALF_MAX = 5,
    parameter int FULL_MAX = 10,
    parameter int IDLE_RUN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_wr,
    input  logic [DIV_W-1:0] baud_val,
    input  logic             rx_en,
    input  logic             coll_clr,
    input  logic             line_in,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             sof_o,
    output logic             eof_o,
    output logic             coll_o
);

    logic  smp_tick;
    logic  ev_edge;
    logic  ev_rise;
    wcls_e ev_cls;
    logic  ev_idle;
    logic  short_ev;

    assign short_ev = ev_edge && (ev_cls == W_SHORT);

    mrx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_wr  (baud_wr),
        .div_val (baud_val),
        .tick    (smp_tick)
    );

    mrx_edge #(
        .RUN_W    (RUN_W),
        .HALF_MIN (HALF_MIN),
        .HALF_MAX (HALF_MAX),
        .FULL_MAX (FULL_MAX),
        .IDLE_RUN (IDLE_RUN)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (smp_tick),
        .line_in (line_in),
        .ev_edge (ev_edge),
        .ev_rise (ev_rise),
        .ev_cls  (ev_cls),
        .ev_idle (ev_idle)
    );

    mrx_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .coll_clr  (coll_clr),
        .ev_edge   (ev_edge),
        .ev_rise   (ev_rise),
        .ev_cls    (ev_cls),
        .ev_idle   (ev_idle),
        .bit_o     (bit_o),
        .bit_vld_o (bit_vld_o),
        .sof_o     (sof_o),
        .eof_o     (eof_o),
        .coll_o    (coll_o)
    );

endmodule

// File: rtl/mrx_chk.sv
module mrx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic coll_clr,
    input logic short_ev,
    input logic bit_vld_o,
    input logic sof_o,
    input logic eof_o,
    input logic coll_o
);

    p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_vld_o, sof_o, eof_o}));

    p_coll_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        short_ev |=> coll_o);

    p_coll_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_o && !coll_clr) |=> coll_o);

    p_coll_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_clr && !short_ev) |=> !coll_o);

    p_rx_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !(bit_vld_o || sof_o || eof_o));

endmodule

bind mrx_top mrx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .coll_clr  (coll_clr),
    .short_ev  (short_ev),
    .bit_vld_o (bit_vld_o),
    .sof_o     (sof_o),
    .eof_o     (eof_o),
    .coll_o    (coll_o)
);

// File: tb/sim_mrx_top.sv
`timescale 1ns/1ps
module sim_mrx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_wr = 1'b0;
    logic [7:0] baud_val = 8'd0;
    logic       rx_en = 1'b1;
    logic       coll_clr = 1'b0;
    logic       line_in = 1'b1;
    logic       bit_o, bit_vld_o, sof_o, eof_o, coll_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int baud_cur = 0;
    int sof_n = 0;
    int eof_n = 0;
    bit rxq[$];
    int tq[$];
    bit smp[$];
    bit expq[$];

    always #2 clk = ~clk;

    mrx_top u0 (
        .clk(clk), .rst_n(rst_n), .baud_wr(baud_wr), .baud_val(baud_val),
        .rx_en(rx_en), .coll_clr(coll_clr), .line_in(line_in),
        .bit_o(bit_o), .bit_vld_o(bit_vld_o), .sof_o(sof_o),
        .eof_o(eof_o), .coll_o(coll_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_vld_o) begin
                rxq.push_back(bit_o);
                tq.push_back(cyc);
            end
            if (sof_o) sof_n++;
            if (eof_o) eof_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_baud(input int b);
        @(negedge clk);
        baud_val = 8'(b);
        baud_wr = 1'b1;
        @(negedge clk);
        baud_wr = 1'b0;
        baud_cur = b;
        repeat (600) @(negedge clk);
    endtask

    task automatic push_lvl(input bit v, input int n);
        for (int i = 0; i < n; i++) smp.push_back(v);
    endtask

    task automatic push_bit(input bit b);
        push_lvl(~b, 4);
        push_lvl(b, 4);
    endtask

    task automatic push_head();
        push_lvl(1'b1, 4);
        for (int i = 0; i < 8; i++) push_bit(i % 2 == 0);
        push_bit(1'b1);
        push_bit(1'b1);
    endtask

    task automatic play();
        sof_n = 0;
        eof_n = 0;
        rxq.delete();
        tq.delete();
        for (int i = 0; i < smp.size(); i++) begin
            line_in = smp[i];
            repeat (baud_cur + 1) @(negedge clk);
        end
        line_in = 1'b1;
        repeat (40) @(negedge clk);
        smp.delete();
    endtask

    task automatic cmp_bits(input string tag);
        bit same;
        same = (rxq.size() == expq.size());
        if (same) begin
            for (int i = 0; i < rxq.size(); i++) if (rxq[i] != expq[i]) same = 1'b0;
        end
        chk(same, tag, rxq.size(), expq.size());
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(coll_o == 1'b0, "R6 reset coll", int'(coll_o), 0);
        chk({bit_vld_o, sof_o, eof_o} == 3'b000, "R2 reset pulses",
            int'({bit_vld_o, sof_o, eof_o}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R2 R7 R9: sweep divider and payloads
        for (int b = 0; b < 4; b++) begin
            set_baud(b);
            for (int p = 0; p < 4; p++) begin
                int data;
                bit good;
                data = (p * 77 + b * 29 + 5) & 255;
                expq.delete();
                push_head();
                for (int k = 0; k < 8; k++) begin
                    push_bit(data[k]);
                    expq.push_back(data[k]);
                end
                push_lvl(1'b1, 24);
                play();
                cmp_bits("R2 payload bits");
                chk(sof_n == 1, "R7 begin marker", sof_n, 1);
                chk(eof_n == 1, "R9 end of frame", eof_n, 1);
                good = (tq.size() == 8);
                for (int i = 1; i < tq.size(); i++)
                    if (tq[i] - tq[i-1] != 8 * (b + 1)) good = 1'b0;
                chk(good, "R1 bit spacing", (tq.size() > 1) ? tq[1] - tq[0] : 0, 8 * (b + 1));
                chk(coll_o == 1'b0, "R4 no collision clean", int'(coll_o), 0);
            end
        end

        set_baud(1);

        // R3: mid-bit edges shifted one sample early
        begin
            int base;
            expq.delete();
            push_head();
            base = smp.size();
            for (int k = 0; k < 8; k++) begin
                push_bit(k[0] ^ k[1]);
                expq.push_back(k[0] ^ k[1]);
            end
            smp[base + 2 * 8 + 3] = expq[2];
            smp[base + 5 * 8 + 3] = expq[5];
            push_lvl(1'b1, 24);
            play();
            cmp_bits("R3 jitter bits");
            chk(coll_o == 1'b0, "R3 jitter no collision", int'(coll_o), 0);
        end

        // R8: two zeros after preamble
        push_lvl(1'b1, 4);
        for (int i = 0; i < 8; i++) push_bit(i % 2 == 0);
        push_bit(1'b0);
        push_bit(1'b0);
        push_lvl(1'b1, 24);
        play();
        chk(sof_n == 0, "R8 no begin on zeros", sof_n, 0);
        chk(rxq.size() == 0, "R8 no bits", rxq.size(), 0);

        // R9: low hold abandons frame without end pulse
        expq.delete();
        push_head();
        push_bit(1'b1); push_bit(1'b0); push_bit(1'b1);
        expq.push_back(1'b1); expq.push_back(1'b0); expq.push_back(1'b1);
        push_lvl(1'b0, 24);
        push_lvl(1'b1, 24);
        play();
        cmp_bits("R9 bits before low hold");
        chk(eof_n == 0, "R9 no end on low hold", eof_n, 0);

        // R4: glitch mid-frame
        expq.delete();
        push_head();
        push_bit(1'b1); push_bit(1'b0); push_bit(1'b1);
        expq.push_back(1'b1); expq.push_back(1'b0); expq.push_back(1'b1);
        smp.push_back(1'b1); smp.push_back(1'b0); smp.push_back(1'b0); smp.push_back(1'b1);
        push_lvl(1'b0, 4);
        for (int i = 0; i < 5; i++) push_bit(1'b0);
        push_lvl(1'b1, 24);
        play();
        chk(coll_o == 1'b1, "R4 collision flag", int'(coll_o), 1);
        cmp_bits("R4 bits stop at collision");
        chk(eof_n == 0, "R4 no end after collision", eof_n, 0);
        repeat (20) @(negedge clk);
        chk(coll_o == 1'b1, "R6 flag sticky", int'(coll_o), 1);

        // R6: clear
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        @(negedge clk);
        chk(coll_o == 1'b0, "R6 clear", int'(coll_o), 0);

        // R10: disabled receiver ignores a valid frame
        rx_en = 1'b0;
        push_head();
        for (int k = 0; k < 8; k++) push_bit(k[0]);
        push_lvl(1'b1, 24);
        play();
        chk(sof_n == 0 && eof_n == 0, "R10 no frame pulses", sof_n + eof_n, 0);
        chk(rxq.size() == 0, "R10 no bits", rxq.size(), 0);

        // R5: collision detection while disabled
        push_lvl(1'b1, 8);
        push_lvl(1'b0, 2);
        push_lvl(1'b1, 20);
        play();
        chk(coll_o == 1'b1, "R5 collision while disabled", int'(coll_o), 1);
        rx_en = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule